// File: doc/BRIEF.md
# Half-Duplex Serial Bus Master

This block is a serial bus master that a host drives through four 16-bit word registers. A single start command runs one transaction on the bus. The transaction first shifts out up to 16 bits from a transmit register, then shifts in up to 16 bits into a receive register. The same command word also carries a sticky select command and a select index, so any one of four peripheral selects can be held active across several transactions.

Each select has its own 6-bit mode field. The field sets:
- the serial clock edge on which outgoing data changes,
- the serial clock edge on which incoming data is sampled,
- the polarity of the select pin,
- the serial clock period, as a divide of the block clock.

The serial clock idles low. Clock prescaling is done outside this block.

The host reads a status view of the command register. It reports a busy flag and a read-data-ready flag, so software can poll for completion. The register index maps to a byte address through a left shift set by a parameter.

Top module: `hdx_serial_master`

## Requirements
- R1: Register index n decodes at byte address n << ADDR_SHIFT. The index map is:
  - Index 0: a write loads the transmit register and a read returns the receive register.
  - Index 1: the command/status register.
  - Index 2: setup register A, which reads back bits 11:0 as written and bits 15:12 as zero.
  - Index 3: setup register B, with the same read-back rule as setup register A.
- R2: The command/status register has these fields:
  - Bit 15: read-data-ready (read-only).
  - Bit 14: busy (read-only).
  - Bit 13: start strobe (reads as 0).
  - Bit 12: select command.
  - Bits 11:10: select index.
  - Bits 9:5: write bit count.
  - Bits 4:0: read bit count.
  
  A read returns bits 12:10 as last written and bits 9:0 as zero.
- R3: While the select command bit is 1, the pin selOut[idx] is active and every other select pin is inactive. While the command bit is 0, all select pins are inactive. The mode field bit 2 sets the polarity of each pin: 1 means active high, 0 means active low. The mode field of select 0 is setup A bits 5:0, select 1 is setup A bits 11:6, select 2 is setup B bits 5:0, and select 3 is setup B bits 11:6.
- R4: Busy reads 1 from the cycle after a start with a nonzero count is written. Busy stays 1 for exactly (write count + read count) × (serial clock period in block cycles) cycles. serClk is low whenever busy is 0.
- R5: The write phase sends the top `write count` bits of the transmit register, most significant bit first, starting from bit 15.
- R6: The read phase shifts in `read count` bits so that the last bit received lands in bit 0 of the receive register, with all higher bits zero. Read-data-ready is set when a transaction with a read phase completes. It is cleared by a read of index 0.
- R7: When a start has both counts nonzero, every write bit period completes before the first read bit period begins.
- R8: Mode bit 1 selects when serOut changes:
  - When bit 1 is 1, serOut changes on the rising serClk edge, and the peripheral samples on the falling edge.
  - When bit 1 is 0, serOut changes at the start of each bit period (on the falling edge between bits), and the peripheral samples on the rising edge.
  
  Mode bit 0 selects when serIn is sampled: on the falling edge when bit 0 is 1, and on the rising edge when bit 0 is 0.
- R9: Mode bits 4:3 set the serClk period: code 00 gives 2 block cycles, code 01 gives 4, and codes 10 and 11 give 8.
- R10: While busy is 1, a write to the command register is ignored entirely. The select pins, the running transaction and its length are all unchanged.
- R11: A start with both counts zero leaves busy at 0 and produces no serClk edge. Count values above 16 are treated as 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regAddr | input | ADDR_W | Byte address of the host access |
| regWr | input | 1 | Host write strobe |
| regRd | input | 1 | Host read strobe (a read of index 0 clears read-data-ready) |
| regWdata | input | 16 | Host write data |
| regRdata | output | 16 | Host read data for regAddr |
| serClk | output | 1 | Serial clock, idles low |
| serOut | output | 1 | Serial data to the peripheral |
| serIn | input | 1 | Serial data from the peripheral |
| selOut | output | 4 | Peripheral selects, polarity per mode |

## Verification
The bench models a peripheral that captures and drives bits on the edges each mode calls for. This exposes a design that changes or samples data on the wrong edge: it would capture shifted or duplicated bits. It also exposes a design that runs read clocks before the write phase ends. The bench counts busy cycles exactly, so an off-by-one in the half-period counter or in the bit count shows up as a wrong length. It does the same for the 1-bit, 16-bit and divide-code-11 corners. A command write during a transaction, and a start with zero counts, are both checked at the select pins and the busy flag. A design that accepted the former would switch selects or restart. A design that mishandled the latter would either hang busy or emit stray clocks.

// File: rtl/hdx_serial_pkg.sv
`timescale 1ns/1ps
package hdx_serial_pkg;
  localparam int WORD_W = 16;
  localparam int CNT_W  = 5;
  localparam int MODE_W = 6;
  localparam int SEL_N  = 4;
  localparam int SEL_W  = 2;

  typedef struct packed {
    logic loadTx;
    logic shiftOut;
    logic sampleIn;
    logic clearRx;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } serState_t;

  function automatic logic [CNT_W-1:0] clampCnt(input logic [CNT_W-1:0] c);
    return (c > CNT_W'(WORD_W)) ? CNT_W'(WORD_W) : c;
  endfunction
endpackage

// File: rtl/hdx_serial_datapath.sv
`timescale 1ns/1ps
module hdx_serial_datapath
  import hdx_serial_pkg::*;
#(
  parameter int DATA_W = WORD_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txWr,
  input  logic [DATA_W-1:0] wdata,
  input  dpStrobe_t         strobe,
  input  logic              serIn,
  output logic              serOut,
  output logic [DATA_W-1:0] rxData
);
  logic [DATA_W-1:0] txReg;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic              outBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
    end else if (txWr) begin
      txReg <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      outBit  <= 1'b0;
    end else if (strobe.loadTx) begin
      if (strobe.shiftOut) begin
        outBit  <= txReg[DATA_W-1];
        txShift <= {txReg[DATA_W-2:0], 1'b0};
      end else begin
        txShift <= txReg;
      end
    end else if (strobe.shiftOut) begin
      outBit  <= txShift[DATA_W-1];
      txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxShift <= '0;
    end else if (strobe.clearRx) begin
      rxShift <= '0;
    end else if (strobe.sampleIn) begin
      rxShift <= {rxShift[DATA_W-2:0], serIn};
    end
  end

  assign serOut = outBit;
  assign rxData = rxShift;
endmodule

// File: rtl/hdx_serial_ctrl.sv
`timescale 1ns/1ps
module hdx_serial_ctrl
  import hdx_serial_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              ctrlWr,
  input  logic              setupAWr,
  input  logic              setupBWr,
  input  logic              dataRd,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] statusWord,
  output logic [WORD_W-1:0] setupAWord,
  output logic [WORD_W-1:0] setupBWord,
  output logic              serClk,
  output logic [SEL_N-1:0]  selOut,
  output dpStrobe_t         strobe,
  output logic              busy,
  output logic              rdReady,
  output logic              inWrite,
  output logic              inRead
);
  localparam int PAIR_W = 2 * MODE_W;

  logic [PAIR_W-1:0] setupA, setupB;
  logic [MODE_W-1:0] modeOf [SEL_N];
  logic [MODE_W-1:0] curMode;
  logic              selCmd;
  logic [SEL_W-1:0]  selIdx;
  serState_t         state;
  logic [1:0]        halfCnt, halfTop;
  logic [CNT_W-1:0]  bitsLeft, rdPending;
  logic [CNT_W-1:0]  wrReq, rdReq;
  logic [SEL_W-1:0]  reqIdx;
  logic              startGo, edgeNow, riseNow, fallNow, lastBit, clkReg;
  logic              unusedHigh;

  assign unusedHigh = ^wdata[WORD_W-1:WORD_W-2];

  generate
    for (genvar i = 0; i < SEL_N; i++) begin : g_sel
      logic selActive;
      if (i < 2) begin : g_a
        assign modeOf[i] = setupA[(i % 2) * MODE_W +: MODE_W];
      end else begin : g_b
        assign modeOf[i] = setupB[(i % 2) * MODE_W +: MODE_W];
      end
      assign selActive = selCmd && (selIdx == SEL_W'(i));
      assign selOut[i] = modeOf[i][2] ? selActive : ~selActive;
    end
  endgenerate

  assign busy    = (state != ST_IDLE);
  assign inWrite = (state == ST_WRITE);
  assign inRead  = (state == ST_READ);
  assign serClk  = clkReg;

  always_comb begin
    wrReq   = clampCnt(wdata[9:5]);
    rdReq   = clampCnt(wdata[4:0]);
    reqIdx  = wdata[11:10];
    startGo = ctrlWr && !busy && wdata[13] && ((wrReq != '0) || (rdReq != '0));
    case (curMode[4:3])
      2'b00:   halfTop = 2'd0;
      2'b01:   halfTop = 2'd1;
      default: halfTop = 2'd3;
    endcase
    edgeNow = busy && (halfCnt == halfTop);
    riseNow = edgeNow && !clkReg;
    fallNow = edgeNow && clkReg;
    lastBit = (bitsLeft == CNT_W'(1));
  end

  always_comb begin
    strobe          = '0;
    strobe.loadTx   = startGo;
    strobe.clearRx  = startGo && (rdReq != '0);
    strobe.shiftOut = (startGo && (wrReq != '0) && !modeOf[reqIdx][1]) ||
                      (inWrite && (curMode[1] ? riseNow : (fallNow && !lastBit)));
    strobe.sampleIn = inRead && (curMode[0] ? fallNow : riseNow);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      setupA <= '0;
      setupB <= '0;
      selCmd <= 1'b0;
      selIdx <= '0;
    end else begin
      if (setupAWr) setupA <= wdata[PAIR_W-1:0];
      if (setupBWr) setupB <= wdata[PAIR_W-1:0];
      if (ctrlWr && !busy) begin
        selCmd <= wdata[12];
        selIdx <= reqIdx;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      clkReg    <= 1'b0;
      bitsLeft  <= '0;
      rdPending <= '0;
      curMode   <= '0;
    end else if (state == ST_IDLE) begin
      if (startGo) begin
        curMode <= modeOf[reqIdx];
        halfCnt <= '0;
        clkReg  <= 1'b0;
        if (wrReq != '0) begin
          state     <= ST_WRITE;
          bitsLeft  <= wrReq;
          rdPending <= rdReq;
        end else begin
          state     <= ST_READ;
          bitsLeft  <= rdReq;
          rdPending <= '0;
        end
      end
    end else if (edgeNow) begin
      halfCnt <= '0;
      clkReg  <= ~clkReg;
      if (clkReg) begin
        if (lastBit) begin
          if (inWrite && (rdPending != '0)) begin
            state     <= ST_READ;
            bitsLeft  <= rdPending;
            rdPending <= '0;
          end else begin
            state <= ST_IDLE;
          end
        end else begin
          bitsLeft <= bitsLeft - CNT_W'(1);
        end
      end
    end else begin
      halfCnt <= halfCnt + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdReady <= 1'b0;
    end else if (inRead && fallNow && lastBit) begin
      rdReady <= 1'b1;
    end else if (dataRd) begin
      rdReady <= 1'b0;
    end
  end

  assign statusWord = {rdReady, busy, 1'b0, selCmd, selIdx, 10'd0};
  assign setupAWord = {{(WORD_W-PAIR_W){1'b0}}, setupA};
  assign setupBWord = {{(WORD_W-PAIR_W){1'b0}}, setupB};
endmodule

// File: rtl/hdx_serial_master.sv
`timescale 1ns/1ps
module hdx_serial_master
  import hdx_serial_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int ADDR_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [WORD_W-1:0] regWdata,
  output logic [WORD_W-1:0] regRdata,
  output logic              serClk,
  output logic              serOut,
  input  logic              serIn,
  output logic [SEL_N-1:0]  selOut
);
  logic [ADDR_W-1:0] regIdx;
  logic              txWr, ctrlWr, setupAWr, setupBWr, dataRd;
  logic              busy, rdReady, inWrite, inRead;
  logic [WORD_W-1:0] statusWord, setupAWord, setupBWord, rxData;
  dpStrobe_t         strobe;

  assign regIdx   = regAddr >> ADDR_SHIFT;
  assign txWr     = regWr && (regIdx == ADDR_W'(0));
  assign ctrlWr   = regWr && (regIdx == ADDR_W'(1));
  assign setupAWr = regWr && (regIdx == ADDR_W'(2));
  assign setupBWr = regWr && (regIdx == ADDR_W'(3));
  assign dataRd   = regRd && (regIdx == ADDR_W'(0));

  hdx_serial_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .setupAWr(setupAWr),
    .setupBWr(setupBWr), .dataRd(dataRd), .wdata(regWdata),
    .statusWord(statusWord), .setupAWord(setupAWord), .setupBWord(setupBWord),
    .serClk(serClk), .selOut(selOut), .strobe(strobe), .busy(busy),
    .rdReady(rdReady), .inWrite(inWrite), .inRead(inRead)
  );

  hdx_serial_datapath #(.DATA_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .txWr(txWr), .wdata(regWdata), .strobe(strobe),
    .serIn(serIn), .serOut(serOut), .rxData(rxData)
  );

  always_comb begin
    case (regIdx)
      ADDR_W'(0): regRdata = rxData;
      ADDR_W'(1): regRdata = statusWord;
      ADDR_W'(2): regRdata = setupAWord;
      ADDR_W'(3): regRdata = setupBWord;
      default:    regRdata = '0;
    endcase
  end
endmodule

// File: rtl/hdx_serial_master_chk.sv
`timescale 1ns/1ps
module hdx_serial_master_chk (
  input logic       clk,
  input logic       rstN,
  input logic       ctrlWr,
  input logic       dataRd,
  input logic       startBit,
  input logic [4:0] wrField,
  input logic [4:0] rdField,
  input logic       busy,
  input logic       rdReady,
  input logic       inWrite,
  input logic       inRead,
  input logic       serClk,
  input logic [3:0] selOut
);
  // R4: busy rises the cycle after an accepted start
  p_busy_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && startBit && !busy && ((wrField != 5'd0) || (rdField != 5'd0))) |=> busy);

  // R4: serial clock low while idle
  p_clk_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !serClk);

  // R10: command writes while busy leave the selects alone
  p_ignore_busy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busy) |=> $stable(selOut));

  // R11: zero-count start never raises busy
  p_zero_start_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && startBit && !busy && (wrField == 5'd0) && (rdField == 5'd0)) |=> !busy);

  // R6: reading data while idle clears read-ready
  p_ready_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !busy) |=> !rdReady);

  // R7: read phase never returns to the write phase
  p_phase_order_r7: assert property (@(posedge clk) disable iff (!rstN)
    inRead |=> !inWrite);
endmodule

bind hdx_serial_master hdx_serial_master_chk u_chk (
  .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .dataRd(dataRd),
  .startBit(regWdata[13]), .wrField(regWdata[9:5]), .rdField(regWdata[4:0]),
  .busy(busy), .rdReady(rdReady), .inWrite(inWrite), .inRead(inRead),
  .serClk(serClk), .selOut(selOut)
);

// File: tb/tb_hdx_serial_master.sv
`timescale 1ns/1ps
module tb_hdx_serial_master;
  localparam int SH = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  regAddr = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regWdata = '0;
  logic        serIn = 1'b0;
  wire  [15:0] regRdata;
  wire         serClk, serOut;
  wire  [3:0]  selOut;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  logic [11:0] sA = '0, sB = '0;
  int riseN = 0, fallN = 0, slvWr = 0, slvRd = 0;
  bit slvWrRising = 0, slvRdFalling = 0;
  logic [15:0] slvTxVal = '0, capWord = '0;
  time t1 = 0, t2 = 0;

  hdx_serial_master #(.ADDR_W(8), .ADDR_SHIFT(SH)) dut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWr(regWr), .regRd(regRd),
    .regWdata(regWdata), .regRdata(regRdata), .serClk(serClk), .serOut(serOut),
    .serIn(serIn), .selOut(selOut)
  );

  always #5 clk = ~clk;

  // peripheral model: rising edges
  initial forever begin
    @(posedge serClk);
    riseN++;
    if (riseN == 1) t1 = $time;
    if (riseN == 2) t2 = $time;
    if (!slvWrRising && riseN <= slvWr) capWord = {capWord[14:0], serOut};
    if (slvRdFalling && riseN > slvWr && riseN <= slvWr + slvRd)
      serIn = slvTxVal[slvRd - 1 - (riseN - slvWr - 1)];
  end

  // peripheral model: falling edges
  initial forever begin
    @(negedge serClk);
    fallN++;
    if (slvWrRising && fallN <= slvWr) capWord = {capWord[14:0], serOut};
    if (!slvRdFalling && fallN >= slvWr && fallN < slvWr + slvRd)
      serIn = slvTxVal[slvRd - 1 - (fallN - slvWr)];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] getMode(input int i);
    return (i < 2) ? sA[(i % 2) * 6 +: 6] : sB[(i % 2) * 6 +: 6];
  endfunction

  function automatic logic [3:0] expSel(input bit cmd, input int idx);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) begin
      logic m2, act;
      m2 = getMode(i) >> 2;
      act = cmd && (idx == i);
      r[i] = m2 ? act : !act;
    end
    return r;
  endfunction

  task automatic wrReg(input int idx, input logic [15:0] d);
    @(negedge clk);
    regAddr = 8'(idx << SH); regWdata = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic peek(input int idx, output logic [15:0] v);
    regAddr = 8'(idx << SH);
    #1 v = regRdata;
  endtask

  task automatic setMode(input int sel, input logic [5:0] m);
    if (sel < 2) begin
      sA[(sel % 2) * 6 +: 6] = m;
      wrReg(2, {4'd0, sA});
    end else begin
      sB[(sel % 2) * 6 +: 6] = m;
      wrReg(3, {4'd0, sB});
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    peek(1, v);
    chk("R2 reset status", v, 16'h0000);
    chk("R3 reset selects inactive", selOut, 4'hF);
    chk("R4 reset clock low", serClk, 1'b0);
  endtask

  task automatic t_regmap();
    logic [15:0] v;
    wrReg(2, 16'hFABC); sA = 12'hABC;
    peek(2, v); chk("R1 setup A readback", v, 16'h0ABC);
    wrReg(3, 16'h5123); sB = 12'h123;
    peek(3, v); chk("R1 setup B readback", v, 16'h0123);
    peek(5, v); chk("R1 unmapped index", v, 16'h0000);
    wrReg(2, 16'h0000); sA = '0;
    wrReg(3, 16'h0000); sB = '0;
  endtask

  task automatic t_select();
    logic [15:0] v;
    setMode(3, 6'b000100);
    chk("R3 inactive active-high pin", selOut, 4'b0111);
    wrReg(1, {3'b000, 1'b1, 2'd2, 10'd0});
    chk("R3 select 2 active low", selOut, expSel(1, 2));
    chk("R3 select 2 pattern", selOut, 4'b0011);
    peek(1, v); chk("R2 command readback", v, 16'h1800);
    wrReg(1, {3'b000, 1'b1, 2'd3, 10'd0});
    chk("R3 select 3 active high", selOut, 4'b1111);
    wrReg(1, {3'b000, 1'b0, 2'd3, 10'd0});
    chk("R3 deassert", selOut, expSel(0, 3));
    peek(1, v); chk("R2 command cleared readback", v, 16'h0C00);
  endtask

  task automatic run(input int sel, input logic [5:0] mode, input int wr, input int rd,
                     input logic [15:0] tx, input logic [15:0] rxv);
    int div, n;
    logic [15:0] st, got;
    logic [4:0] w5, r5;
    div = (mode[4:3] == 2'b00) ? 2 : (mode[4:3] == 2'b01) ? 4 : 8;
    w5 = 5'(wr); r5 = 5'(rd);
    setMode(sel, mode);
    wrReg(0, tx);
    slvWrRising = mode[1]; slvRdFalling = mode[0];
    slvWr = wr; slvRd = rd; slvTxVal = rxv;
    riseN = 0; fallN = 0; capWord = '0; t1 = 0; t2 = 0;
    if (wr == 0 && rd > 0 && !mode[0]) serIn = rxv[rd - 1];
    wrReg(1, {2'b00, 1'b1, 1'b1, 2'(sel), w5, r5});
    chk("R3 select during transfer", selOut, expSel(1, sel));
    n = 0;
    regAddr = 8'(1 << SH);
    #1;
    while (regRdata[14] && n < 2000) begin
      n++;
      @(negedge clk);
      #1;
    end
    chk("R4 busy length", n, (wr + rd) * div);
    chk("R4 clock low after done", serClk, 1'b0);
    if (wr > 0) chk("R5/R8 bits sent", capWord, tx >> (16 - wr));
    if (wr + rd >= 2) chk("R9 serial clock period", 32'(t2 - t1), 32'(div * 10));
    st = regRdata;
    if (rd > 0) begin
      chk("R6 read ready set", st[15], 1'b1);
      @(negedge clk);
      regAddr = 8'd0; regRd = 1'b1;
      #1 got = regRdata;
      @(negedge clk);
      regRd = 1'b0; regAddr = 8'(1 << SH);
      if (wr > 0) chk("R7 read after write data", got, rxv);
      else        chk("R6/R8 received data", got, rxv);
      #1 chk("R6 read ready cleared", regRdata[15], 1'b0);
    end else begin
      chk("R6 no ready on write-only", st[15], 1'b0);
    end
  endtask

  task automatic t_ignore();
    int n;
    setMode(1, 6'b010000);
    wrReg(0, 16'h9600);
    slvWrRising = 0; slvRdFalling = 0; slvWr = 8; slvRd = 0;
    riseN = 0; fallN = 0; capWord = '0;
    wrReg(1, {3'b001, 1'b1, 2'd1, 5'd8, 5'd0});
    n = 0;
    regAddr = 8'(1 << SH);
    #1;
    while (regRdata[14] && n < 2000) begin
      n++;
      if (n == 3) begin
        regWdata = {3'b001, 1'b0, 2'd3, 5'd16, 5'd16};
        regWr = 1'b1;
      end else begin
        regWr = 1'b0;
      end
      @(negedge clk);
      #1;
    end
    regWr = 1'b0;
    chk("R10 length unchanged", n, 64);
    chk("R10 select unchanged", selOut, expSel(1, 1));
    chk("R10 data unchanged", capWord, 16'h0096);
    chk("R10 command fields unchanged", regRdata[12:10], 3'b101);
  endtask

  task automatic t_zero();
    logic [15:0] v;
    int clkHigh;
    riseN = 0;
    wrReg(1, {3'b001, 1'b1, 2'd0, 5'd0, 5'd0});
    peek(1, v);
    chk("R11 zero count not busy", v[14], 1'b0);
    clkHigh = 0;
    repeat (6) begin
      @(negedge clk);
      if (serClk) clkHigh++;
    end
    chk("R11 no clock edges", clkHigh + riseN, 0);
    chk("R11 select still applied", selOut, expSel(1, 0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_regmap();
    t_select();
    run(0, 6'b000000, 8, 0, 16'hA53C, 16'h0000);
    run(1, 6'b001011, 16, 0, 16'h8E71, 16'h0000);
    run(2, 6'b010001, 0, 12, 16'h0000, 16'h0B3D);
    run(3, 6'b001010, 5, 7, 16'hD800, 16'h005A);
    run(0, 6'b011000, 3, 16, 16'h6000, 16'hC0DE);
    run(1, 6'b000000, 0, 1, 16'h0000, 16'h0001);
    t_ignore();
    t_zero();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      vecs++;
      errs++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule